// File: doc/BRIEF.md
# DMX512 Slot Receiver with Break Sync and Byte Realignment

This block takes one asynchronous serial line carrying a lighting-control stream. The line runs at 250 kbit/s. Each character has a low start bit, eight data bits sent LSB first, no parity and two high stop bits. The block turns the stream into slot writes for an external 512-entry buffer.

A long low period on the line (a break) marks the start of a frame. The first character after a break is the start code. Every later character is written to the buffer at the next slot address, through a write strobe that is held until the buffer accepts it. The receiver tells a real break apart from a corrupted character. After a framing error, an overrun or a too-short mark, it drops the rest of the packet.

The line is sampled on a clock-enable tick at sixteen times the bit rate. At the nominal rate that tick is 4 MHz, so one tick is 0.25 µs. After it is enabled, or after any error, the receiver waits for one full character time of idle line before it trusts a falling edge as a start bit. This lets it recover byte alignment when it is switched on in the middle of a live stream.

Top module: `dmx_rx`

## Requirements
- R1: Each bit lasts 16 ticks and is sampled at its middle. A low on an armed line is confirmed as a start bit only if it is still low 8 ticks later; a shorter low pulse is ignored and produces no character and no error.
- R2: A break is a low that lasts at least 352 ticks (88 µs), either as an all-zero character whose first stop bit is low, or while the receiver is waiting for idle. A break resets the slot pointer, and the next good character is presented on `start_code`.
- R3: The characters after the start code are written in order to `slot_addr` 0, 1, 2 and so on. `slot_we` stays high, with address and data stable, until `slot_rdy` is high.
- R4: At most SLOTS (default 512) slots are written per frame. Characters after the last slot are dropped, and the pointer does not move.
- R5: `frame_done` pulses for one cycle when the SLOTS-th slot write is issued. It also pulses on a break that ends a frame which was started but not yet complete.
- R6: A character whose first stop bit is low, and which does not go on to become a break, sets `err_frm` and `err_pkt`. This includes an all-zero character whose low lasts less than 352 ticks.
- R7: After any error, no further slot write is issued until the next break. The slot writes after that break start again at address 0.
- R8: If a character completes while a slot write is still waiting for `slot_rdy`, the block sets `err_ovr` and `err_pkt`. The new character is discarded, and the waiting write is kept.
- R9: A high period after a break (the mark) that is shorter than 32 ticks (8 µs) sets `err_pkt`.
- R10: After `en` rises, and after any error, the line must be high for 176 consecutive ticks (44 µs) before a falling edge is accepted as a start bit.
- R11: `err_frm`, `err_ovr` and `err_pkt` are sticky. They return to 0 only on a `clear` pulse.
- R12: While `en` is low the line is ignored, and no start code or slot write results.
- R13: After reset, `slot_we`, `frame_done`, all error flags and `start_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Receiver enable |
| os_tick | input | 1 | Clock enable at 16x the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| clear | input | 1 | Clears the sticky error flags |
| slot_rdy | input | 1 | Buffer accepts the pending slot write |
| slot_we | output | 1 | Slot write request |
| slot_addr | output | AW (9) | Slot index, 0 for the first channel |
| slot_data | output | 8 | Slot value |
| start_code | output | 8 | Start code of the latest frame |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| err_frm | output | 1 | Sticky framing error |
| err_ovr | output | 1 | Sticky overrun |
| err_pkt | output | 1 | Sticky packet error |

## Verification
Two situations are hard to reach from the ports.

The first is overrun. It needs a slot write held back by `slot_rdy` across a whole character time. The stimulus holds `slot_rdy` low through a frame of two slots. It then releases `slot_rdy` and confirms that only the first slot lands.

The second is the idle gate. It can only be seen through the framing flag. The bench sends a character with a low stop bit less than one character time after enable and expects no error. It then sends the same character after a long idle and expects `err_frm`. The break threshold is also probed from both sides: a 340-tick low gives a framing error, and an exact 352-tick low gives a sync.

// File: rtl/dmx_rx_pkg.sv
package dmx_rx_pkg;

    typedef enum logic [2:0] {
        CS_HUNT,
        CS_IDLE,
        CS_START,
        CS_DATA,
        CS_STOP,
        CS_BRK,
        CS_BLOW,
        CS_MAB
    } cstate_e;

    typedef struct packed {
        logic       chr;
        logic       brk;
        logic       ferr;
        logic       maberr;
        logic [7:0] data;
    } rx_ev_t;

endpackage

// File: rtl/dmx_line_sync.sv
module dmx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= sr_d;
    end

    assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/dmx_char_rx.sv
module dmx_char_rx
    import dmx_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int IDLE_TICKS  = 176,
    parameter int BREAK_TICKS = 352,
    parameter int MAB_TICKS   = 32
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  logic   tick,
    input  logic   rx,
    input  logic   resync,
    output rx_ev_t ev
);
    localparam int HALF = OSR / 2;
    localparam int MAXA = (BREAK_TICKS > IDLE_TICKS) ? BREAK_TICKS : IDLE_TICKS;
    localparam int MAXT = (MAXA > MAB_TICKS) ? MAXA : MAB_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    typedef struct packed {
        cstate_e       st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] lrun;
        logic [2:0]    bitn;
        logic [7:0]    sh;
        rx_ev_t        ev;
    } cst_t;

    cst_t q, n;
    logic brk_now;

    assign brk_now = !rx && (q.lrun >= CW'(BREAK_TICKS - 1));

    always_comb begin
        n    = q;
        n.ev = '0;
        if (tick) begin
            if (rx)                               n.lrun = '0;
            else if (q.lrun != CW'(BREAK_TICKS))  n.lrun = q.lrun + 1'b1;

            unique case (q.st)
                CS_HUNT: begin
                    if (brk_now) begin
                        n.ev.brk = 1'b1;
                        n.st     = CS_BLOW;
                    end else if (rx) begin
                        if (q.cnt == CW'(IDLE_TICKS - 1)) begin
                            n.st  = CS_IDLE;
                            n.cnt = '0;
                        end else begin
                            n.cnt = q.cnt + 1'b1;
                        end
                    end else begin
                        n.cnt = '0;
                    end
                end
                CS_IDLE: begin
                    if (!rx) begin
                        n.st  = CS_START;
                        n.cnt = '0;
                    end
                end
                CS_START: begin
                    if (q.cnt == CW'(HALF - 1)) begin
                        n.cnt  = '0;
                        n.bitn = '0;
                        n.st   = rx ? CS_IDLE : CS_DATA;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                CS_DATA: begin
                    if (q.cnt == CW'(OSR - 1)) begin
                        n.cnt  = '0;
                        n.sh   = {rx, q.sh[7:1]};
                        n.bitn = q.bitn + 3'd1;
                        if (q.bitn == 3'd7) n.st = CS_STOP;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                CS_STOP: begin
                    if (q.cnt == CW'(OSR - 1)) begin
                        n.cnt = '0;
                        if (rx) begin
                            n.ev.chr  = 1'b1;
                            n.ev.data = q.sh;
                            n.st      = CS_IDLE;
                        end else if (q.sh == 8'h00) begin
                            n.st = CS_BRK;
                        end else begin
                            n.ev.ferr = 1'b1;
                            n.st      = CS_HUNT;
                        end
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                CS_BRK: begin
                    if (rx) begin
                        n.ev.ferr = 1'b1;
                        n.st      = CS_HUNT;
                        n.cnt     = '0;
                    end else if (brk_now) begin
                        n.ev.brk = 1'b1;
                        n.st     = CS_BLOW;
                    end
                end
                CS_BLOW: begin
                    if (rx) begin
                        n.st  = CS_MAB;
                        n.cnt = CW'(1);
                    end
                end
                CS_MAB: begin
                    if (!rx) begin
                        n.ev.maberr = 1'b1;
                        n.st        = CS_HUNT;
                        n.cnt       = '0;
                    end else if (q.cnt == CW'(MAB_TICKS - 1)) begin
                        n.st  = CS_IDLE;
                        n.cnt = '0;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                default: begin
                    n.st  = CS_HUNT;
                    n.cnt = '0;
                end
            endcase
        end
        if (!en || resync) begin
            n.st  = CS_HUNT;
            n.cnt = '0;
        end
        if (!en) n.ev = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= CS_HUNT;
        end else begin
            q <= n;
        end
    end

    assign ev = q.ev;
endmodule

// File: rtl/dmx_frame_ctl.sv
module dmx_frame_ctl
    import dmx_rx_pkg::*;
#(
    parameter int SLOTS = 512,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          clear,
    input  rx_ev_t        ev,
    input  logic          slot_rdy,
    output logic          slot_we,
    output logic [AW-1:0] slot_addr,
    output logic [7:0]    slot_data,
    output logic [7:0]    start_code,
    output logic          frame_done,
    output logic          err_frm,
    output logic          err_ovr,
    output logic          err_pkt,
    output logic          resync
);
    localparam int PW = $clog2(SLOTS + 2);

    typedef struct packed {
        logic          synced;
        logic          drop;
        logic          done;
        logic          pending;
        logic [PW-1:0] ptr;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [7:0]    sc;
        logic          ferr;
        logic          oerr;
        logic          perr;
        logic          fdone;
        logic          resync;
    } fst_t;

    fst_t q, n;

    always_comb begin
        n        = q;
        n.fdone  = 1'b0;
        n.resync = 1'b0;
        if (q.pending && slot_rdy) n.pending = 1'b0;
        if (clear) begin
            n.ferr = 1'b0;
            n.oerr = 1'b0;
            n.perr = 1'b0;
        end
        if (!en) n.synced = 1'b0;

        if (ev.brk) begin
            if (q.ptr != '0 && !q.done) n.fdone = 1'b1;
            n.ptr    = '0;
            n.done   = 1'b0;
            n.drop   = 1'b0;
            n.synced = 1'b1;
        end
        if (ev.ferr) begin
            n.ferr = 1'b1;
            n.perr = 1'b1;
            n.drop = 1'b1;
        end
        if (ev.maberr) begin
            n.perr = 1'b1;
            n.drop = 1'b1;
        end
        if (ev.chr) begin
            if (q.pending && !slot_rdy) begin
                n.oerr   = 1'b1;
                n.perr   = 1'b1;
                n.drop   = 1'b1;
                n.resync = 1'b1;
            end else if (q.synced && !q.drop) begin
                if (q.ptr == '0) begin
                    n.sc  = ev.data;
                    n.ptr = PW'(1);
                end else if (q.ptr <= PW'(SLOTS)) begin
                    n.pending = 1'b1;
                    n.addr    = AW'(q.ptr - PW'(1));
                    n.data    = ev.data;
                    n.ptr     = q.ptr + PW'(1);
                    if (q.ptr == PW'(SLOTS)) begin
                        n.fdone = 1'b1;
                        n.done  = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign slot_we    = q.pending;
    assign slot_addr  = q.addr;
    assign slot_data  = q.data;
    assign start_code = q.sc;
    assign frame_done = q.fdone;
    assign err_frm    = q.ferr;
    assign err_ovr    = q.oerr;
    assign err_pkt    = q.perr;
    assign resync     = q.resync;
endmodule

// File: rtl/dmx_rx.sv
module dmx_rx
    import dmx_rx_pkg::*;
#(
    parameter int SLOTS       = 512,
    parameter int OSR         = 16,
    parameter int IDLE_TICKS  = 176,
    parameter int BREAK_TICKS = 352,
    parameter int MAB_TICKS   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   en,
    input  logic                                   os_tick,
    input  logic                                   rx_in,
    input  logic                                   clear,
    input  logic                                   slot_rdy,
    output logic                                   slot_we,
    output logic [((SLOTS > 1) ? $clog2(SLOTS) : 1)-1:0] slot_addr,
    output logic [7:0]                             slot_data,
    output logic [7:0]                             start_code,
    output logic                                   frame_done,
    output logic                                   err_frm,
    output logic                                   err_ovr,
    output logic                                   err_pkt
);
    localparam int AW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic   rx_s;
    logic   resync;
    rx_ev_t ev;

    dmx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_in),
        .dout  (rx_s)
    );

    dmx_char_rx #(
        .OSR         (OSR),
        .IDLE_TICKS  (IDLE_TICKS),
        .BREAK_TICKS (BREAK_TICKS),
        .MAB_TICKS   (MAB_TICKS)
    ) u_char (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .tick   (os_tick),
        .rx     (rx_s),
        .resync (resync),
        .ev     (ev)
    );

    dmx_frame_ctl #(.SLOTS(SLOTS), .AW(AW)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .clear      (clear),
        .ev         (ev),
        .slot_rdy   (slot_rdy),
        .slot_we    (slot_we),
        .slot_addr  (slot_addr),
        .slot_data  (slot_data),
        .start_code (start_code),
        .frame_done (frame_done),
        .err_frm    (err_frm),
        .err_ovr    (err_ovr),
        .err_pkt    (err_pkt),
        .resync     (resync)
    );
endmodule

// File: rtl/dmx_rx_chk.sv
module dmx_rx_chk #(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clear,
    input logic          slot_rdy,
    input logic          slot_we,
    input logic [AW-1:0] slot_addr,
    input logic [7:0]    slot_data,
    input logic          frame_done,
    input logic          err_frm,
    input logic          err_ovr,
    input logic          err_pkt
);
    // R3
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_we && !slot_rdy) |=> (slot_we && $stable(slot_addr) && $stable(slot_data)));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R11
    pkt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pkt && !clear) |=> err_pkt);

    // R11
    frm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frm && !clear) |=> err_frm);

    // R11
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovr && !clear) |=> err_ovr);

    // R8
    ovr_marks_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ovr) |-> err_pkt);

    // R6
    frm_marks_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_frm) |-> err_pkt);
endmodule

bind dmx_rx dmx_rx_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .slot_rdy   (slot_rdy),
    .slot_we    (slot_we),
    .slot_addr  (slot_addr),
    .slot_data  (slot_data),
    .frame_done (frame_done),
    .err_frm    (err_frm),
    .err_ovr    (err_ovr),
    .err_pkt    (err_pkt)
);

// File: tb/dmx_rx_tb_top.sv
module dmx_rx_tb_top;
    localparam int SLOTS = 8;
    localparam int AW    = 3;
    localparam logic [23:0] VEC [4] = '{24'h00_10_04, 24'h17_A0_08,
                                        24'hCC_00_0B, 24'h00_FF_01};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic os_tick = 1'b1;
    logic rx = 1'b1;
    logic clear = 1'b0;
    logic slot_rdy = 1'b1;
    logic          slot_we;
    logic [AW-1:0] slot_addr;
    logic [7:0]    slot_data;
    logic [7:0]    start_code;
    logic          frame_done;
    logic          err_frm, err_ovr, err_pkt;

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    int fd_cnt = 0;
    logic [AW-1:0] cap_a [0:1023];
    logic [7:0]    cap_d [0:1023];

    always #10 clk = ~clk;

    dmx_rx #(.SLOTS(SLOTS)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .os_tick    (os_tick),
        .rx_in      (rx),
        .clear      (clear),
        .slot_rdy   (slot_rdy),
        .slot_we    (slot_we),
        .slot_addr  (slot_addr),
        .slot_data  (slot_data),
        .start_code (start_code),
        .frame_done (frame_done),
        .err_frm    (err_frm),
        .err_ovr    (err_ovr),
        .err_pkt    (err_pkt)
    );

    always @(posedge clk) begin
        if (slot_we && slot_rdy) begin
            cap_a[wr_cnt & 1023] <= slot_addr;
            cap_d[wr_cnt & 1023] <= slot_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (frame_done) fd_cnt <= fd_cnt + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n, input logic lvl);
        rx = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input logic stop_ok);
        ticks(16, 1'b0);
        for (int i = 0; i < 8; i++) ticks(16, d[i]);
        ticks(16, stop_ok);
        ticks(16, 1'b1);
    endtask

    task automatic send_break(input int lo, input int mab);
        ticks(lo, 1'b0);
        ticks(mab, 1'b1);
    endtask

    task automatic pulse_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int wb, fb, m, errs, expfd;
        logic [7:0] sc, base, n, expd;
        bit prev_open;
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13 slot_we", int'(slot_we), 0);
        check("R13 flags", int'({err_frm, err_ovr, err_pkt, frame_done}), 0);
        check("R13 start_code", int'(start_code), 0);
        rst_n = 1'b1;
        ticks(20, 1'b1);

        // R12: disabled receiver ignores a full frame
        wb = wr_cnt;
        send_break(400, 40);
        send_char(8'h5C, 1'b1);
        send_char(8'h40, 1'b1);
        send_char(8'h41, 1'b1);
        ticks(40, 1'b1);
        check("R12 writes", wr_cnt - wb, 0);
        check("R12 start_code", int'(start_code), 0);

        // R10: bad character too soon after enable is ignored
        en = 1'b1;
        ticks(100, 1'b1);
        send_char(8'h0F, 1'b0);
        ticks(10, 1'b1);
        check("R10 early", int'(err_frm), 0);
        ticks(200, 1'b1);
        send_char(8'h0F, 1'b0);
        ticks(10, 1'b1);
        check("R10 after idle", int'(err_frm), 1);
        pulse_clear();
        check("R11 clear", int'({err_frm, err_ovr, err_pkt}), 0);
        ticks(200, 1'b1);

        // Table of frames: R2 R3 R4 R5
        prev_open = 1'b0;
        for (int v = 0; v < 4; v++) begin
            sc   = VEC[v][23:16];
            base = VEC[v][15:8];
            n    = VEC[v][7:0];
            wb   = wr_cnt;
            fb   = fd_cnt;
            send_break(400, 32);
            send_char(sc, 1'b1);
            for (int k = 0; k < int'(n); k++) send_char(base + 8'(k), 1'b1);
            ticks(40, 1'b1);
            m = (int'(n) < SLOTS) ? int'(n) : SLOTS;
            check("R4 count", wr_cnt - wb, m);
            errs = 0;
            for (int k = 0; k < m; k++) begin
                expd = base + 8'(k);
                if (int'(cap_a[(wb + k) & 1023]) != k || cap_d[(wb + k) & 1023] != expd)
                    errs++;
            end
            check("R3 data", errs, 0);
            check("R2 start_code", int'(start_code), int'(sc));
            expfd = (prev_open ? 1 : 0) + ((int'(n) >= SLOTS) ? 1 : 0);
            check("R5 frame_done", fd_cnt - fb, expfd);
            prev_open = (int'(n) > 0) && (int'(n) < SLOTS);
        end
        check("R7 no error in clean frames", int'({err_frm, err_ovr, err_pkt}), 0);

        // R6 R7: corrupted character mid-packet, then recovery at break
        wb = wr_cnt;
        send_break(400, 40);
        send_char(8'h00, 1'b1);
        send_char(8'h11, 1'b1);
        send_char(8'h22, 1'b1);
        send_char(8'h55, 1'b0);
        ticks(200, 1'b1);
        send_char(8'h33, 1'b1);
        send_char(8'h44, 1'b1);
        ticks(40, 1'b1);
        check("R6 err_frm", int'(err_frm), 1);
        check("R6 err_pkt", int'(err_pkt), 1);
        check("R7 suppressed", wr_cnt - wb, 2);
        wb = wr_cnt;
        send_break(400, 40);
        send_char(8'h00, 1'b1);
        send_char(8'h66, 1'b1);
        ticks(40, 1'b1);
        check("R7 resume count", wr_cnt - wb, 1);
        check("R7 resume data", int'({cap_a[wb & 1023], cap_d[wb & 1023]}), int'({3'd0, 8'h66}));
        check("R11 sticky", int'(err_pkt), 1);
        pulse_clear();
        check("R11 cleared", int'({err_frm, err_ovr, err_pkt}), 0);

        // R6 R2: 340-tick low is a framing error, not a break
        send_break(400, 40);
        send_char(8'h21, 1'b1);
        wb = wr_cnt;
        send_break(340, 200);
        send_char(8'h02, 1'b1);
        ticks(40, 1'b1);
        check("R6 short zero low", int'(err_frm), 1);
        check("R6 not a break", int'(start_code), 8'h21);
        check("R7 dropped after short low", wr_cnt - wb, 0);
        pulse_clear();

        // R2: exactly 352 ticks is a break
        ticks(200, 1'b1);
        wb = wr_cnt;
        send_break(352, 40);
        send_char(8'h3E, 1'b1);
        send_char(8'h9A, 1'b1);
        ticks(40, 1'b1);
        check("R2 exact break start", int'(start_code), 8'h3E);
        check("R2 exact break write", wr_cnt - wb, 1);
        check("R2 no error", int'(err_frm), 0);

        // R9: short mark after break
        wb = wr_cnt;
        send_break(400, 16);
        send_char(8'h00, 1'b1);
        send_char(8'h77, 1'b1);
        ticks(40, 1'b1);
        check("R9 err_pkt", int'(err_pkt), 1);
        check("R9 no write", wr_cnt - wb, 0);
        check("R9 not framing", int'(err_frm), 0);
        pulse_clear();

        // R8: overrun while write waits
        ticks(200, 1'b1);
        slot_rdy = 1'b0;
        wb = wr_cnt;
        send_break(400, 40);
        send_char(8'h00, 1'b1);
        send_char(8'hA1, 1'b1);
        send_char(8'hA2, 1'b1);
        ticks(40, 1'b1);
        check("R8 err_ovr", int'(err_ovr), 1);
        check("R8 err_pkt", int'(err_pkt), 1);
        check("R8 held", int'(slot_we), 1);
        slot_rdy = 1'b1;
        ticks(5, 1'b1);
        check("R8 one write", wr_cnt - wb, 1);
        check("R8 kept data", int'(cap_d[wb & 1023]), 8'hA1);
        pulse_clear();

        // R1: short low glitch ignored between characters
        ticks(200, 1'b1);
        wb = wr_cnt;
        send_break(400, 40);
        send_char(8'h00, 1'b1);
        send_char(8'h5A, 1'b1);
        ticks(4, 1'b0);
        ticks(40, 1'b1);
        send_char(8'hA5, 1'b1);
        ticks(40, 1'b1);
        check("R1 glitch count", wr_cnt - wb, 2);
        check("R1 glitch data", int'({cap_d[wb & 1023], cap_d[(wb + 1) & 1023]}), 16'h5AA5);
        check("R1 glitch no error", int'({err_frm, err_pkt}), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule